// File: doc/BRIEF.md
# Multi-Window Inbound Address Translator

This block decides, for each address arriving from a processor-side bus, whether one of eight software-programmed windows should forward the cycle onto a downstream PCI bus. Each window has a base register, a translation register and a control word. The control word holds:
- an enable bit and a translation-enable bit;
- a power-of-two size code;
- a target-space mode;
- an endian selection;
- a prefetch amount and a keep-prefetch bit;
- a requester filter.

A global bus-master-enable bit gates every claim. The block does not run the downstream transaction.

Software writes and reads the registers through a plain single-cycle register port. Lookups enter through a valid/ready request interface. A result leaves one cycle later through a valid/ready response interface. A response is held, unchanged, for as long as `rsp_ready` stays low. While a response is stalled, `req_ready` is low and no new request is taken. When the response slot is empty or is being drained in the same cycle, `req_ready` is high.

Top module: `xw_xlate_top`

## Requirements
- R1: After reset every register reads 0, so no window is enabled and no request is claimed. Register select `reg_addr[4:2]` picks the window and `reg_addr[1:0]` picks the register: 0 is base, 1 is translation, 2 is control, 3 is the global register. Bit 0 of the global register is the bus-master enable, and any window index reaches it.
- R2: A window matches only when control bit 31 (enable) is 1. Its size is 4 KByte shifted left by the size code in control bits 28:24, with the code capped at 19. Only address bits at or above log2(size) are compared with the base register.
- R3: When control bit 30 (translate) is 1 on the winning window, the address bits at or above the window size come from the translation register and the lower bits come from the request. For example, base 0x20000000 with size code 16 and translation 0 maps 0x20001234 to 0x00001234.
- R4: When translate is 0 on the winning window, or when no window matches, `rsp_addr` equals the request address.
- R5: If control bit 29 (all requesters) is 0, the window matches only when `req_master` equals control bits 3:0. If the bit is 1, `req_master` is ignored.
- R6: If several windows match, the lowest-numbered one wins. `rsp_hit` is one-hot on it, or zero when nothing matches, and `rsp_miss` is 1 exactly when `rsp_hit` is zero.
- R7: `rsp_claim` is 1 only when a window matches and the bus-master enable is 1. A match with the enable at 0 still reports `rsp_hit`, but `rsp_claim` stays 0.
- R8: The winning window's attributes appear on the response, and all of them are 0 on a miss. `rsp_io` is 1 when control bits 21:20 are nonzero, which selects I/O space; a value of 0 selects memory space. `rsp_endian` comes from bits 17:16, where 2 means big-endian. `rsp_keep` comes from bit 12. `rsp_rd_amt` comes from bits 10:8, where 0 means an 8-byte prefetch.
- R9: The response appears one cycle after the request is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select: window index and register kind |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | 32 | Processor-bus address |
| req_master | input | 4 | Requester identifier |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_claim | output | 1 | Cycle is forwarded downstream |
| rsp_hit | output | 8 | One-hot winning window |
| rsp_miss | output | 1 | No window matched |
| rsp_addr | output | 32 | Downstream address |
| rsp_io | output | 1 | 1 = I/O space, 0 = memory space |
| rsp_endian | output | 2 | Byte-order selection |
| rsp_keep | output | 1 | Keep leftover prefetched data |
| rsp_rd_amt | output | 3 | Prefetch amount code |

## Verification
A register write takes effect at the clock edge where it is presented, so its new value is read back half a cycle later. A lookup presented at a falling edge is captured at the next rising edge, and its response is sampled at the falling edge after that. The expected result comes from a bench model of the registers as they stood at capture time. During stall tests the response is sampled again after further falling edges to confirm it has held, and the bench drops the request before releasing the stall.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int unsigned PAGE_LG = 12;
  // control word field positions
  localparam int unsigned C_EN      = 31;
  localparam int unsigned C_XL      = 30;
  localparam int unsigned C_ALL     = 29;
  localparam int unsigned C_SZ_LO   = 24;
  localparam int unsigned C_SZ_W    = 5;
  localparam int unsigned C_MODE_LO = 20;
  localparam int unsigned C_END_LO  = 16;
  localparam int unsigned C_KEEP    = 12;
  localparam int unsigned C_RD_LO   = 8;
  localparam int unsigned C_OWN_LO  = 0;

  typedef enum logic [1:0] {
    K_BASE = 2'd0,
    K_XLAT = 2'd1,
    K_CTRL = 2'd2,
    K_GLOB = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic       io;
    logic [1:0] endian;
    logic       keep;
    logic [2:0] rd_amt;
  } attr_t;
endpackage

// File: rtl/xw_window.sv
module xw_window
  import xw_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_base,
  input  logic          wr_xlat,
  input  logic          wr_ctrl,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] lk_addr,
  input  logic [MW-1:0] lk_master,
  output logic [31:0]   base_q,
  output logic [31:0]   xlat_q,
  output logic [31:0]   ctrl_q,
  output logic          hit,
  output logic [AW-1:0] xaddr,
  output attr_t         attr
);
  localparam int unsigned MAX_CODE = AW - PAGE_LG - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      xlat_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_xlat) xlat_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  logic [C_SZ_W-1:0] code_raw;
  logic [C_SZ_W-1:0] code;
  logic [AW-1:0]     hi_mask;
  logic              who_ok;

  always_comb begin
    code_raw = ctrl_q[C_SZ_LO +: C_SZ_W];
    code     = (32'(code_raw) > MAX_CODE) ? C_SZ_W'(MAX_CODE) : code_raw;
    hi_mask  = ~((AW'(1) << (PAGE_LG + 32'(code))) - AW'(1));
    who_ok   = ctrl_q[C_ALL] || (lk_master == ctrl_q[C_OWN_LO +: MW]);
    hit      = ctrl_q[C_EN] && who_ok &&
               (((lk_addr ^ base_q[AW-1:0]) & hi_mask) == '0);
    xaddr    = ctrl_q[C_XL] ? ((xlat_q[AW-1:0] & hi_mask) | (lk_addr & ~hi_mask))
                            : lk_addr;
    attr.io     = |ctrl_q[C_MODE_LO +: 2];
    attr.endian = ctrl_q[C_END_LO +: 2];
    attr.keep   = ctrl_q[C_KEEP];
    attr.rd_amt = ctrl_q[C_RD_LO +: 3];
  end

  // R1
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctrl) && $past(rst_n) |-> $stable(ctrl_q));
  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ctrl_q[C_EN]);
endmodule

// File: rtl/xw_prio.sv
module xw_prio
  import xw_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32
) (
  input  logic [NWIN-1:0]         hit_vec,
  input  logic [NWIN-1:0][AW-1:0] xaddr_vec,
  input  attr_t [NWIN-1:0]        attr_vec,
  input  logic [AW-1:0]           pass_addr,
  output logic [NWIN-1:0]         win_oh,
  output logic [AW-1:0]           sel_addr,
  output attr_t                   sel_attr
);
  always_comb begin
    win_oh   = hit_vec & (~hit_vec + NWIN'(1));
    sel_addr = pass_addr;
    sel_attr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_addr = xaddr_vec[i];
        sel_attr = attr_vec[i];
      end
    end
  end
endmodule

// File: rtl/xw_xlate_top.sv
module xw_xlate_top
  import xw_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned AW   = 32,
  parameter int unsigned MW   = 4,
  localparam int unsigned SW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [SW+1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [MW-1:0]   req_master,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_claim,
  output logic [NWIN-1:0] rsp_hit,
  output logic            rsp_miss,
  output logic [AW-1:0]   rsp_addr,
  output logic            rsp_io,
  output logic [1:0]      rsp_endian,
  output logic            rsp_keep,
  output logic [2:0]      rsp_rd_amt
);
  reg_kind_e      kind;
  logic [SW-1:0]  wsel;
  logic           master_en;

  logic [NWIN-1:0][31:0]   base_a, xlat_a, ctrl_a;
  logic [NWIN-1:0]         hit_vec;
  logic [NWIN-1:0][AW-1:0] xaddr_vec;
  attr_t [NWIN-1:0]        attr_vec;
  logic [NWIN-1:0]         win_oh;
  logic [AW-1:0]           sel_addr;
  attr_t                   sel_attr;

  assign kind = reg_kind_e'(reg_addr[1:0]);
  assign wsel = reg_addr[SW+1:2];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic here;
    assign here = reg_we && (wsel == SW'(g));
    xw_window #(.AW(AW), .MW(MW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (here && kind == K_BASE),
      .wr_xlat  (here && kind == K_XLAT),
      .wr_ctrl  (here && kind == K_CTRL),
      .wdata    (reg_wdata),
      .lk_addr  (req_addr),
      .lk_master(req_master),
      .base_q   (base_a[g]),
      .xlat_q   (xlat_a[g]),
      .ctrl_q   (ctrl_a[g]),
      .hit      (hit_vec[g]),
      .xaddr    (xaddr_vec[g]),
      .attr     (attr_vec[g])
    );
  end

  xw_prio #(.NWIN(NWIN), .AW(AW)) u_prio (
    .hit_vec  (hit_vec),
    .xaddr_vec(xaddr_vec),
    .attr_vec (attr_vec),
    .pass_addr(req_addr),
    .win_oh   (win_oh),
    .sel_addr (sel_addr),
    .sel_attr (sel_attr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) master_en <= 1'b0;
    else if (reg_we && kind == K_GLOB) master_en <= reg_wdata[0];
  end

  always_comb begin
    unique case (kind)
      K_BASE:  reg_rdata = base_a[wsel];
      K_XLAT:  reg_rdata = xlat_a[wsel];
      K_CTRL:  reg_rdata = ctrl_a[wsel];
      default: reg_rdata = {31'd0, master_en};
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_claim  <= 1'b0;
      rsp_hit    <= '0;
      rsp_miss   <= 1'b0;
      rsp_addr   <= '0;
      rsp_io     <= 1'b0;
      rsp_endian <= '0;
      rsp_keep   <= 1'b0;
      rsp_rd_amt <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_claim  <= (|win_oh) && master_en;
        rsp_hit    <= win_oh;
        rsp_miss   <= ~|win_oh;
        rsp_addr   <= sel_addr;
        rsp_io     <= sel_attr.io;
        rsp_endian <= sel_attr.endian;
        rsp_keep   <= sel_attr.keep;
        rsp_rd_amt <= sel_attr.rd_amt;
      end
    end
  end

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_hit) && (rsp_miss == (rsp_hit == '0)));
  // R7
  claim_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_claim |-> !rsp_miss);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                                && $stable(rsp_claim));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

// File: tb/test_xw_xlate_top.sv
module test_xw_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_master = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_claim;
  logic [7:0]  rsp_hit;
  logic        rsp_miss;
  logic [31:0] rsp_addr;
  logic        rsp_io;
  logic [1:0]  rsp_endian;
  logic        rsp_keep;
  logic [2:0]  rsp_rd_amt;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_base [8];
  logic [31:0] m_xlat [8];
  logic [31:0] m_ctrl [8];
  logic        m_men;

  always #5 clk = ~clk;

  xw_xlate_top i_xw_xlate_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_master(req_master),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_claim(rsp_claim),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_addr(rsp_addr), .rsp_io(rsp_io),
    .rsp_endian(rsp_endian), .rsp_keep(rsp_keep), .rsp_rd_amt(rsp_rd_amt)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int win, input int kind, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'((win << 2) | kind); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (kind == 3) m_men = d[0];
    else if (kind == 0) m_base[win] = d;
    else if (kind == 1) m_xlat[win] = d;
    else m_ctrl[win] = d;
  endtask

  function automatic logic [31:0] ctl(bit en, bit xl, bit all, int sz, int mode,
                                     int endn, bit keep, int rd, int own);
    return {en, xl, all, 5'(sz), 2'b0, 2'(mode), 2'b0, 2'(endn), 3'b0, keep,
            1'b0, 3'(rd), 4'b0, 4'(own)};
  endfunction

  // expected result from the requirement text
  task automatic model(input logic [31:0] a, input logic [3:0] m,
                       output int win, output logic [31:0] xa);
    win = -1; xa = a;
    for (int i = 0; i < 8; i++) begin
      int code = int'(m_ctrl[i][28:24]);
      logic [31:0] hm;
      if (code > 19) code = 19;
      hm = ~((32'd1 << (12 + code)) - 32'd1);
      if (win < 0 && m_ctrl[i][31] && (m_ctrl[i][29] || m == m_ctrl[i][3:0]) &&
          ((a ^ m_base[i]) & hm) == 0) begin
        win = i;
        if (m_ctrl[i][30]) xa = (m_xlat[i] & hm) | (a & ~hm);
      end
    end
  endtask

  task automatic lookup(input string tag, input logic [31:0] a, input logic [3:0] m);
    int w; logic [31:0] xa; logic [31:0] c;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_master = m;
    @(negedge clk);
    req_valid = 1'b0;
    model(a, m, w, xa);
    c = (w >= 0) ? m_ctrl[w] : 32'd0;
    check({tag, " R9 valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " R6 hit"}, 64'(rsp_hit), (w >= 0) ? 64'(8'(1) << w) : 64'd0);
    check({tag, " R6 miss"}, 64'(rsp_miss), 64'(w < 0));
    check({tag, " R7 claim"}, 64'(rsp_claim), 64'((w >= 0) && m_men));
    check({tag, " R3 R4 addr"}, 64'(rsp_addr), 64'(xa));
    check({tag, " R8 attr"}, 64'({rsp_io, rsp_endian, rsp_keep, rsp_rd_amt}),
          64'({|c[21:20], c[17:16], c[12], c[10:8]}));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_xlat[i] = 0; m_ctrl[i] = 0; end
    m_men = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 32; i++) begin
      reg_addr = 5'(i); #1;
      check("R1 reset read", 64'(reg_rdata), 64'd0);
    end
    check("R1 idle valid", 64'(rsp_valid), 64'd0);
    lookup("R1 closed", 32'h2000_0000, 4'd0);

    // example mapping, master off then on
    wr(0, 0, 32'h2000_0000);
    wr(0, 1, 32'h0000_0000);
    wr(0, 2, ctl(1, 1, 1, 16, 0, 2, 0, 0, 0));
    reg_addr = 5'd2; #1;
    check("R1 readback ctrl", 64'(reg_rdata), 64'(m_ctrl[0]));
    lookup("R7 master off", 32'h2000_1234, 4'd3);
    wr(5, 3, 32'd1);
    reg_addr = 5'd3; #1;
    check("R1 global read", 64'(reg_rdata), 64'd1);
    lookup("R3 example", 32'h2000_1234, 4'd3);
    check("R3 example addr", 64'(rsp_addr), 64'h0000_1234);
    lookup("R2 edge top", 32'h2FFF_FFFF, 4'd0);
    lookup("R2 just above", 32'h3000_0000, 4'd0);
    lookup("R2 just below", 32'h1FFF_FFFF, 4'd0);

    // R2 enable off: other fields set but no match
    wr(1, 0, 32'h4000_0000);
    wr(1, 2, ctl(0, 1, 1, 0, 1, 1, 1, 3, 0));
    lookup("R2 disabled", 32'h4000_0010, 4'd0);
    // R4 translation off, R8 io mode
    wr(1, 1, 32'hABC0_0000);
    wr(1, 2, ctl(1, 0, 1, 0, 2, 1, 1, 5, 0));
    lookup("R4 pass", 32'h4000_0FF0, 4'd0);
    // R6 overlap: window 2 covers window 1 region, window 1 wins
    wr(2, 0, 32'h4000_0000);
    wr(2, 2, ctl(1, 1, 1, 8, 1, 0, 0, 7, 0));
    lookup("R6 overlap low", 32'h4000_0004, 4'd0);
    lookup("R6 overlap high", 32'h4000_2000, 4'd0);
    // R5 requester filter
    wr(3, 0, 32'h8000_0000);
    wr(3, 1, 32'h0100_0000);
    wr(3, 2, ctl(1, 1, 0, 4, 0, 2, 0, 1, 9));
    lookup("R5 owner", 32'h8000_0ABC, 4'd9);
    lookup("R5 other", 32'h8000_0ABC, 4'd8);
    // R2 size code cap at 19
    wr(4, 0, 32'h0000_0000);
    wr(4, 2, ctl(1, 1, 1, 31, 0, 0, 0, 0, 0));
    wr(4, 1, 32'hFFFF_FFFF);
    lookup("R2 cap low", 32'h7000_0001, 4'd0);
    lookup("R2 cap high", 32'hF000_0001, 4'd0);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h2000_0040; req_master = 0;
    @(negedge clk);
    req_addr = 32'h8000_0000; req_master = 4'd9;
    check("R9 ready low", 64'(req_ready), 64'd0);
    check("R9 first addr", 64'(rsp_addr), 64'h0000_0040);
    repeat (2) @(negedge clk);
    check("R9 held addr", 64'(rsp_addr), 64'h0000_0040);
    check("R9 held valid", 64'(rsp_valid), 64'd1);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", 64'(rsp_valid), 64'd0);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int w = int'($urandom_range(0, 7));
      int k = int'($urandom_range(0, 3));
      logic [31:0] d = $urandom;
      if (k == 2) d = ctl(d[31], d[30], d[29], int'($urandom_range(0, 21)),
                          int'(d[21:20]), int'(d[17:16]), d[12], int'(d[10:8]),
                          int'($urandom_range(0, 3)));
      if (n % 3 == 0) wr(w, k, d);
      begin
        int b = int'($urandom_range(0, 7));
        logic [31:0] a = m_base[b] ^ ($urandom >> $urandom_range(4, 31));
        lookup("R2 R3 R5 R6 R8 random", a, 4'($urandom_range(0, 3)));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule